// File: doc/BRIEF.md
# Integer Execution Unit for a 32-bit RISC Core

This block computes the integer result of one register-register or register-immediate operation of a 32-bit RISC core. Each cycle it takes the same inputs a decoder already has. These are the 3-bit function field, instruction bit 30, and a flag that marks the immediate form. It also takes the first source operand and a second operand. The second operand is either the second source register or the immediate, which has already been sign-extended to 32 bits. The block supports addition, subtraction, the three bitwise operations, three kinds of shift, and signed and unsigned set-if-less-than.

The datapath between input and output is combinational. It ends in a single output register. That register loads only when the input valid strobe is high, so the result stays in place until the next operation is issued. Register-file access, immediate extraction and pipeline control are handled outside the block.

Top module: `int_exec_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `res_valid` and `res_q` both become 0.
- R2: One edge after a cycle with `in_valid` high, `res_valid` is 1 and `res_q` holds the result for the inputs of that cycle. After a cycle with `in_valid` low, `res_valid` is 0 and `res_q` keeps its previous value.
- R3: With `fn_sel` = 3'b000 in register form (`imm_form` = 0), the result is `opa + opb` when `alt_sel` = 0 and `opa - opb` when `alt_sel` = 1, both modulo 2^32.
- R4: With `fn_sel` = 3'b000 in immediate form (`imm_form` = 1), the result is always `opa + opb`, whatever the value of `alt_sel`.
- R5: `fn_sel` = 3'b100 gives XOR, 3'b110 gives OR and 3'b111 gives AND. Each works bitwise on `opa` and `opb` exactly as presented, so a sign-extended immediate of 0xfffff800 applied to 0x55551111 gives 0x55551000 for AND and 0xfffff911 for OR.
- R6: `fn_sel` = 3'b001 shifts `opa` left, filling with zeros. The shift amount is `opb[4:0]`, and bits 31..5 of `opb` are ignored. For example, 0x12345678 shifted by 8 gives 0x34567800.
- R7: `fn_sel` = 3'b101 shifts `opa` right by `opb[4:0]`. It fills with zeros when `alt_sel` = 0 and with copies of bit 31 when `alt_sel` = 1, in both forms. For example, 0x87654321 shifted by 8 gives 0x00876543 with zero fill and 0xff876543 with sign fill.
- R8: `fn_sel` = 3'b010 gives 1 when `opa` < `opb` as two's-complement signed values, and 0 otherwise.
- R9: `fn_sel` = 3'b011 gives 1 when `opa` < `opb` as unsigned values, and 0 otherwise. A sign-extended immediate such as 0xfffff800 is compared as a large unsigned number.
- R10: For every function code other than 3'b000 and 3'b101, `alt_sel` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Issue strobe; loads the result register |
| fn_sel | input | 3 | Function code (encodings as listed in R3 to R9) |
| alt_sel | input | 1 | Instruction bit 30: selects subtract or sign fill |
| imm_form | input | 1 | 1 when `opb` carries a sign-extended immediate |
| opa | input | 32 | First source operand |
| opb | input | 32 | Second register or sign-extended immediate |
| res_valid | output | 1 | Result register holds a new result |
| res_q | output | 32 | Registered result |

## Verification
Directed cases cover the corner cases named in R5 to R9:
- sign-extended immediates with bit 11 set, which separate sign extension from zero extension;
- shift amounts of 0 and 31, and values with garbage in the upper bits of `opb`;
- operand pairs where signed and unsigned ordering disagree, such as 0x80000000 against 1.

Random operands, function codes and form flags then run against a model in the bench. Random `alt_sel` values separate the two encodings that honour bit 30 from those that must ignore it, including the immediate add that must never turn into a subtract. A hold phase with `in_valid` low and changing inputs separates a result register that loads on every edge from one that loads only when `in_valid` is high.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

  // Function-field encodings seen at the block's inputs
  localparam logic [2:0] FN_ADD  = 3'b000;
  localparam logic [2:0] FN_SLL  = 3'b001;
  localparam logic [2:0] FN_SLT  = 3'b010;
  localparam logic [2:0] FN_SLTU = 3'b011;
  localparam logic [2:0] FN_XOR  = 3'b100;
  localparam logic [2:0] FN_SHR  = 3'b101;
  localparam logic [2:0] FN_OR   = 3'b110;
  localparam logic [2:0] FN_AND  = 3'b111;

  // Internal operation after bit-30 and form resolution
  typedef enum logic [3:0] {
    K_ADD, K_SUB, K_SHL, K_SLT, K_SLTU, K_XOR, K_SHRL, K_SHRA, K_OR, K_AND
  } op_kind_e;

endpackage

// File: rtl/int_exec_decode.sv
module int_exec_decode
  import int_exec_pkg::*;
(
  input  logic [2:0] fn_sel,
  input  logic       alt_sel,
  input  logic       imm_form,
  output op_kind_e   kind
);
  always_comb begin
    unique case (fn_sel)
      // Bit 30 separates subtract from add only in register form (R3, R4)
      FN_ADD:  kind = (alt_sel && !imm_form) ? K_SUB : K_ADD;
      FN_SLL:  kind = K_SHL;
      FN_SLT:  kind = K_SLT;
      FN_SLTU: kind = K_SLTU;
      FN_XOR:  kind = K_XOR;
      // Bit 30 picks the right-shift fill in both forms (R7)
      FN_SHR:  kind = alt_sel ? K_SHRA : K_SHRL;
      FN_OR:   kind = K_OR;
      default: kind = K_AND;
    endcase
  end
endmodule

// File: rtl/int_exec_shifter.sv
module int_exec_shifter #(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] din,
  input  logic [SHW-1:0]  amt,
  input  logic            left,
  input  logic            arith,
  output logic [XLEN-1:0] dout
);
  logic [XLEN-1:0] stg [0:SHW];
  logic [XLEN-1:0] rev_in, rev_out;
  logic            fill;

  // A left shift reuses the right shifter on bit-reversed data
  always_comb begin
    for (int i = 0; i < XLEN; i++) rev_in[i] = din[XLEN-1-i];
  end

  assign stg[0] = left ? rev_in : din;
  assign fill   = arith & ~left & din[XLEN-1];

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stg[k+1] = amt[k] ? {{STEP{fill}}, stg[k][XLEN-1:STEP]} : stg[k];
  end

  always_comb begin
    for (int i = 0; i < XLEN; i++) rev_out[i] = stg[SHW][XLEN-1-i];
  end

  assign dout = left ? rev_out : stg[SHW];
endmodule

// File: rtl/int_exec_compare.sv
module int_exec_compare #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            lt_s,
  output logic            lt_u
);
  logic [XLEN:0] diff;

  // The borrow out of a - b is the unsigned ordering
  assign diff = {1'b0, a} - {1'b0, b};
  assign lt_u = diff[XLEN];
  // When the signs differ, the negative operand is the smaller one
  assign lt_s = (a[XLEN-1] ^ b[XLEN-1]) ? a[XLEN-1] : lt_u;
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import int_exec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [2:0]      fn_sel,
  input  logic            alt_sel,
  input  logic            imm_form,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic            res_valid,
  output logic [XLEN-1:0] res_q
);
  localparam int SHW = $clog2(XLEN);

  op_kind_e        kind;
  logic [XLEN-1:0] sum, shifted, result;
  logic            lt_s, lt_u, do_sub;

  int_exec_decode u_dec (
    .fn_sel(fn_sel), .alt_sel(alt_sel), .imm_form(imm_form), .kind(kind)
  );

  // A single adder serves both add and subtract
  assign do_sub = (kind == K_SUB);
  assign sum    = opa + (opb ^ {XLEN{do_sub}}) + {{(XLEN-1){1'b0}}, do_sub};

  int_exec_shifter #(.XLEN(XLEN)) u_shf (
    .din(opa), .amt(opb[SHW-1:0]),
    .left(kind == K_SHL), .arith(kind == K_SHRA), .dout(shifted)
  );

  int_exec_compare #(.XLEN(XLEN)) u_cmp (
    .a(opa), .b(opb), .lt_s(lt_s), .lt_u(lt_u)
  );

  always_comb begin
    unique case (kind)
      K_ADD, K_SUB:           result = sum;
      K_SHL, K_SHRL, K_SHRA:  result = shifted;
      K_SLT:                  result = {{(XLEN-1){1'b0}}, lt_s};
      K_SLTU:                 result = {{(XLEN-1){1'b0}}, lt_u};
      K_XOR:                  result = opa ^ opb;
      K_OR:                   result = opa | opb;
      default:                result = opa & opb;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_q     <= '0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) res_q <= result;
    end
  end
endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [2:0]      fn_sel,
  input logic            alt_sel,
  input logic            imm_form,
  input logic [XLEN-1:0] opa,
  input logic [XLEN-1:0] opb,
  input logic            res_valid,
  input logic [XLEN-1:0] res_q
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!res_valid && res_q == '0));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!res_valid && $stable(res_q)));

  a_r3_sub_self_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fn_sel == 3'b000 && !imm_form && alt_sel && opa == opb)
      |=> res_q == '0);

  a_r4_imm_add_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fn_sel == 3'b000 && imm_form && opb == '0)
      |=> res_q == $past(opa));

  a_r7_sign_fill: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fn_sel == 3'b101 && alt_sel && opa[XLEN-1])
      |=> res_q[XLEN-1]);

  a_r8_slt_boolean: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fn_sel == 3'b010) |=> res_q[XLEN-1:1] == '0);

  a_r9_sltu_boolean: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fn_sel == 3'b011) |=> res_q[XLEN-1:1] == '0);
endmodule

bind int_exec_unit int_exec_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .fn_sel(fn_sel),
  .alt_sel(alt_sel), .imm_form(imm_form), .opa(opa), .opb(opb),
  .res_valid(res_valid), .res_q(res_q)
);

// File: tb/tb_int_exec_unit.sv
`timescale 1ns/1ps
module tb_int_exec_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  fn_sel = '0;
  logic        alt_sel = 1'b0;
  logic        imm_form = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic        res_valid;
  logic [31:0] res_q;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  int_exec_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .fn_sel(fn_sel),
    .alt_sel(alt_sel), .imm_form(imm_form), .opa(opa), .opb(opb),
    .res_valid(res_valid), .res_q(res_q)
  );

  function automatic logic [31:0] model(input logic [2:0] f, input logic alt,
                                        input logic imm, input logic [31:0] a,
                                        input logic [31:0] b);
    case (f)
      3'b000:  return (alt && !imm) ? a - b : a + b;
      3'b001:  return a << b[4:0];
      3'b010:  return {31'd0, $signed(a) < $signed(b)};
      3'b011:  return {31'd0, a < b};
      3'b100:  return a ^ b;
      3'b101:  return alt ? 32'($signed(a) >>> b[4:0]) : a >> b[4:0];
      3'b110:  return a | b;
      default: return a & b;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] f, input logic imm);
    case (f)
      3'b000:  return imm ? "R4" : "R3";
      3'b001:  return "R6";
      3'b010:  return "R8";
      3'b011:  return "R9";
      3'b101:  return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // Drive at the falling edge, then sample at the next falling edge
  task automatic run(input string tag, input logic [2:0] f, input logic alt,
                     input logic imm, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    in_valid = 1'b1; fn_sel = f; alt_sel = alt; imm_form = imm; opa = a; opb = b;
    @(negedge clk);
    check(tag, {31'd0, res_valid}, 32'd1);
    check(tag, res_q, model(f, alt, imm, a, b));
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #500000;
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {31'd0, res_valid}, 32'd0);
    check("R1", res_q, 32'd0);
    rst = 1'b0;

    run("R3", 3'b000, 1'b0, 1'b0, 32'hffffffff, 32'h00000001);
    check("R3", res_q, 32'h0);
    run("R3", 3'b000, 1'b1, 1'b0, 32'h00000000, 32'h00000001);
    check("R3", res_q, 32'hffffffff);
    run("R4", 3'b000, 1'b1, 1'b1, 32'h00000010, 32'hfffffffc);
    check("R4", res_q, 32'h0000000c);
    run("R5", 3'b111, 1'b0, 1'b1, 32'h55551111, 32'hfffff800);
    check("R5", res_q, 32'h55551000);
    run("R5", 3'b110, 1'b0, 1'b1, 32'h55551111, 32'hfffff800);
    check("R5", res_q, 32'hfffff911);
    run("R5", 3'b100, 1'b0, 1'b0, 32'h55551111, 32'hff00ff00);
    check("R5", res_q, 32'haa55ee11);
    run("R6", 3'b001, 1'b0, 1'b0, 32'h12345678, 32'hffffffe8);
    check("R6", res_q, 32'h34567800);
    run("R7", 3'b101, 1'b1, 1'b0, 32'h87654321, 32'h00000008);
    check("R7", res_q, 32'hff876543);
    run("R7", 3'b101, 1'b0, 1'b1, 32'h87654321, 32'h00000008);
    check("R7", res_q, 32'h00876543);
    run("R7", 3'b101, 1'b1, 1'b1, 32'h80000000, 32'h0000001f);
    check("R7", res_q, 32'hffffffff);
    run("R6", 3'b001, 1'b0, 1'b1, 32'hdeadbeef, 32'h00000000);
    check("R6", res_q, 32'hdeadbeef);
    run("R8", 3'b010, 1'b0, 1'b0, 32'h80000000, 32'h00000001);
    check("R8", res_q, 32'd1);
    run("R9", 3'b011, 1'b0, 1'b0, 32'h80000000, 32'h00000001);
    check("R9", res_q, 32'd0);
    run("R9", 3'b011, 1'b0, 1'b1, 32'h00001234, 32'hfffff800);
    check("R9", res_q, 32'd1);
    run("R8", 3'b010, 1'b0, 1'b1, 32'h00001234, 32'hfffff800);
    check("R8", res_q, 32'd0);
    // R10: bit 30 ignored outside add/sub and right shift
    run("R10", 3'b110, 1'b1, 1'b0, 32'h0f0f0000, 32'h000000f0);
    check("R10", res_q, 32'h0f0f00f0);
    run("R10", 3'b001, 1'b1, 1'b1, 32'h00000001, 32'h00000004);
    check("R10", res_q, 32'h00000010);

    // R2: idle cycles hold the result while inputs change
    held = res_q;
    @(negedge clk);
    in_valid = 1'b0; fn_sel = 3'b100; opa = 32'h13572468; opb = 32'hffffffff;
    repeat (2) @(negedge clk);
    check("R2", {31'd0, res_valid}, 32'd0);
    check("R2", res_q, held);

    for (int n = 0; n < 400; n++) begin
      logic [2:0]  f = 3'($urandom);
      logic        imm = 1'($urandom);
      logic        alt = 1'($urandom);
      logic [31:0] a = $urandom;
      logic [31:0] b = imm ? {{20{1'($urandom)}}, 12'($urandom)} : $urandom;
      if (n % 5 == 0) a = {1'($urandom), 31'd0};
      run((alt && f != 3'b000 && f != 3'b101) ? "R10" : tag_of(f, imm),
          f, alt, imm, a, b);
    end

    // R1: reset in mid-stream clears the register
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check("R1", {31'd0, res_valid}, 32'd0);
    check("R1", res_q, 32'd0);

    summary();
    $finish;
  end
endmodule